// File: doc/BRIEF.md
# 48-bit Compare Timer

This block is a memory-mapped system timer. A 48-bit up-counter advances once per clock while the run bit is set. Two compare channels, A and B, each hold a 48-bit target. When the counter steps onto a channel's target, that channel's pending flag is set. Software enables each channel onto one interrupt line. It also clears each flag separately, through dedicated write-one registers.

Software reaches the block over a plain 32-bit register bus, with one-cycle write and read strobes and combinational read data. The count is wider than a bus word, so it has two read views:
- a buffered pair: reading the high word freezes the whole count, so the low word read next belongs to the same instant;
- a live pair with no buffering.

A preset path either loads the counter with a chosen value or clears it.

Top module: `wide_cmp_timer`

## Requirements
- R1: After reset the counter, the control register, both enable bits and both pending flags are 0, and `irq` is low.
- R2: A read of 0x20 returns count bits 47:32 in bits 15:0 (upper bits zero) and captures the full count in a buffer. A read of 0x24 returns bits 31:0 of that buffer. Reads of 0x28 and 0x2C return bits 47:32 and 31:0 of the live count.
- R3: Bit 0 of the control register (0x00, readable) is the run bit. While it is 0 the counter holds its value.
- R4: A write to 0x30 stores a preset word, readable at 0x30. A write to 0x34 then loads the counter. If bit 30 of the stored word is 1 the counter loads zero. Otherwise it loads {stored bits 15:0, written word}.
- R5: A compare value is written high word first (A at 0x10, B at 0x18) and low word second (A at 0x14, B at 0x1C). The high word is held aside until the low write commits both halves together. Reads of these addresses return the committed value.
- R6: When the counter advances by one onto a channel's compare value, that channel's raw flag sets. Flags read at 0x44, with bit 0 for A and bit 1 for B. The flag stays set until cleared. A preset load never sets a flag.
- R7: Writing 1 to a bit of 0x50 clears that channel's flag, and writing 0 leaves it unchanged. A match in the same cycle as the clear wins, and the flag stays set.
- R8: Writing 1 to a bit of 0x48 sets that channel's enable, and writing 1 to a bit of 0x4C clears it. A 0 bit leaves the enable unchanged. Masked status at 0x40 is raw flags AND enables. `irq` is the OR of the two masked bits.
- R9: While running, the counter rises by exactly one per clock. It wraps from all ones to zero, and the wrap raises no flag unless a compare value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (captures the buffered count) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, OR of the masked channel flags |

## Verification
Two functions can land on the same clock edge: the counter stepping onto compare A's target, and a software write that clears A's flag. The bench presets the counter one below the target and starts it. It then issues the flag-clear write so that it takes effect on the very edge where the match occurs. It judges the result by reading raw status and `irq` after stopping the counter: the flag must still be set. A second clear, made with no match present, must then leave the flag at 0.

// File: rtl/tmr_pkg.sv
// Shared constants for the compare timer: register byte addresses and
// channel indices. The addresses are the software contract of the block.
package tmr_pkg;
    localparam int NCH = 2;
    localparam int CH_A = 0;
    localparam int CH_B = 1;

    localparam logic [7:0] A_CTRL    = 8'h00;
    localparam logic [7:0] A_CMPA_HI = 8'h10;
    localparam logic [7:0] A_CMPA_LO = 8'h14;
    localparam logic [7:0] A_CMPB_HI = 8'h18;
    localparam logic [7:0] A_CMPB_LO = 8'h1C;
    localparam logic [7:0] A_BCNT_HI = 8'h20;
    localparam logic [7:0] A_BCNT_LO = 8'h24;
    localparam logic [7:0] A_LCNT_HI = 8'h28;
    localparam logic [7:0] A_LCNT_LO = 8'h2C;
    localparam logic [7:0] A_PRE_HI  = 8'h30;
    localparam logic [7:0] A_PRE_LO  = 8'h34;
    localparam logic [7:0] A_MSTAT   = 8'h40;
    localparam logic [7:0] A_RSTAT   = 8'h44;
    localparam logic [7:0] A_ENSET   = 8'h48;
    localparam logic [7:0] A_ENCLR   = 8'h4C;
    localparam logic [7:0] A_FLGCLR  = 8'h50;

    localparam int PRE_ZERO_BIT = 30;
endpackage

// File: rtl/tmr_counter.sv
// Free-running up-counter with a load port.
// Assumes: a load has priority over a step; the step wraps modulo 2**CNT_W.
// Provides the step flag and the stepped value so compare logic can detect
// a match on the same edge that the counter moves.
module tmr_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             step,
    output logic [CNT_W-1:0] step_val
);
    logic [CNT_W-1:0] cnt_q;

    // step happens only when running and no load competes
    always_comb begin
        step     = run && !ld_en;
        step_val = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    // counter register: reset, load, step or hold
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (ld_en)   cnt_q <= ld_val;
        else if (run)     cnt_q <= step_val;
    end

    assign cnt = cnt_q;

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_en) |=> (cnt_q == $past(cnt_q)));
    // R9
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_en) |=> (cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1}));
    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (cnt_q == $past(ld_val)));
endmodule

// File: rtl/tmr_cmp_chan.sv
// One compare channel: a staged 48-bit target, a sticky match flag and an
// enable bit.
// Assumes: the high word is written before the low word, and the low write
// commits both halves. A match seen on the same edge as a flag clear wins.
module tmr_cmp_chan #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic [31:0]      wdata,
    input  logic             step,
    input  logic [CNT_W-1:0] step_val,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] target,
    output logic             flag,
    output logic             en
);
    localparam int HI_W = CNT_W - 32;

    logic [HI_W-1:0]  hi_stage_q;
    logic [CNT_W-1:0] target_q;
    logic             flag_q;
    logic             en_q;
    logic             hit;

    // match when the counter steps onto the committed target
    assign hit = step && (step_val == target_q);

    // stage high word, commit whole target on the low write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage_q <= '0;
            target_q   <= '0;
        end else begin
            if (hi_we) hi_stage_q <= wdata[HI_W-1:0];
            if (lo_we) target_q   <= {hi_stage_q, wdata};
        end
    end

    // sticky flag: set by match, cleared by write-one, match wins
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // enable bit driven by separate set and clear strobes
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (en_set) en_q <= 1'b1;
        else if (en_clr) en_q <= 1'b0;
    end

    assign target = target_q;
    assign flag   = flag_q;
    assign en     = en_q;

    // R6
    rise_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(hit));
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !flag_q);
    // R7
    hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);
endmodule

// File: rtl/wide_cmp_timer.sv
// Top of the compare timer: bus decode, control and preset registers,
// the buffered count view and the interrupt combine.
// Assumes: single-cycle bus strobes, combinational read data, and
// CNT_W between 33 and 64 so the high count half fits one bus word.
module wide_cmp_timer #(
    parameter int CNT_W = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import tmr_pkg::*;

    localparam int HI_W  = CNT_W - 32;
    localparam int PAD_W = 32 - HI_W;

    logic             run_q;
    logic [31:0]      pre_hi_q;
    logic [CNT_W-1:0] cnt_buf_q;
    logic [CNT_W-1:0] cnt;
    logic             step;
    logic [CNT_W-1:0] step_val;
    logic             ld_en;
    logic [CNT_W-1:0] ld_val;
    logic             cap;

    logic [NCH-1:0]   hi_we, lo_we, en_set, en_clr, flag_clr;
    logic [NCH-1:0]   flag, en;
    logic [CNT_W-1:0] target [NCH];
    logic [NCH-1:0]   masked;

    // decode of strobes that act on the counter path
    always_comb begin
        ld_en  = bus_wr && (bus_addr == A_PRE_LO);
        ld_val = pre_hi_q[PRE_ZERO_BIT] ? '0 : {pre_hi_q[HI_W-1:0], bus_wdata};
        cap    = bus_rd && (bus_addr == A_BCNT_HI);
    end

    // decode of per-channel strobes
    always_comb begin
        hi_we[CH_A]  = bus_wr && (bus_addr == A_CMPA_HI);
        lo_we[CH_A]  = bus_wr && (bus_addr == A_CMPA_LO);
        hi_we[CH_B]  = bus_wr && (bus_addr == A_CMPB_HI);
        lo_we[CH_B]  = bus_wr && (bus_addr == A_CMPB_LO);
        en_set   = (bus_wr && (bus_addr == A_ENSET))  ? bus_wdata[NCH-1:0] : '0;
        en_clr   = (bus_wr && (bus_addr == A_ENCLR))  ? bus_wdata[NCH-1:0] : '0;
        flag_clr = (bus_wr && (bus_addr == A_FLGCLR)) ? bus_wdata[NCH-1:0] : '0;
    end

    // control and preset-word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            pre_hi_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL)   run_q    <= bus_wdata[0];
            if (bus_addr == A_PRE_HI) pre_hi_q <= bus_wdata;
        end
    end

    // buffer the whole count when its high half is read
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_buf_q <= '0;
        else if (cap) cnt_buf_q <= cnt;
    end

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .ld_en    (ld_en),
        .ld_val   (ld_val),
        .cnt      (cnt),
        .step     (step),
        .step_val (step_val)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_cmp_chan #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .hi_we    (hi_we[g]),
            .lo_we    (lo_we[g]),
            .wdata    (bus_wdata),
            .step     (step),
            .step_val (step_val),
            .en_set   (en_set[g]),
            .en_clr   (en_clr[g]),
            .flag_clr (flag_clr[g]),
            .target   (target[g]),
            .flag     (flag[g]),
            .en       (en[g])
        );
    end

    // interrupt combine
    always_comb begin
        masked = flag & en;
        irq    = |masked;
    end

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:    bus_rdata = {31'b0, run_q};
            A_CMPA_HI: bus_rdata = {{PAD_W{1'b0}}, target[CH_A][CNT_W-1:32]};
            A_CMPA_LO: bus_rdata = target[CH_A][31:0];
            A_CMPB_HI: bus_rdata = {{PAD_W{1'b0}}, target[CH_B][CNT_W-1:32]};
            A_CMPB_LO: bus_rdata = target[CH_B][31:0];
            A_BCNT_HI: bus_rdata = {{PAD_W{1'b0}}, cnt[CNT_W-1:32]};
            A_BCNT_LO: bus_rdata = cnt_buf_q[31:0];
            A_LCNT_HI: bus_rdata = {{PAD_W{1'b0}}, cnt[CNT_W-1:32]};
            A_LCNT_LO: bus_rdata = cnt[31:0];
            A_PRE_HI:  bus_rdata = pre_hi_q;
            A_MSTAT:   bus_rdata = {{(32-NCH){1'b0}}, masked};
            A_RSTAT:   bus_rdata = {{(32-NCH){1'b0}}, flag};
            default:   bus_rdata = '0;
        endcase
    end

    // R2
    buf_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (cnt_buf_q == $past(cnt)));
    // R2
    buf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> (cnt_buf_q == $past(cnt_buf_q)));
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);
endmodule

// File: tb/wide_cmp_timer_tb.sv
module wide_cmp_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    wide_cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // entered at a negedge; the write acts on the next posedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preset(input logic [31:0] hi, input logic [31:0] lo);
        wr(8'h30, hi); wr(8'h34, lo);
    endtask

    task automatic set_cmp(input logic [7:0] hi_a, input logic [31:0] hi, input logic [31:0] lo);
        wr(hi_a, hi); wr(hi_a + 8'h4, lo);
    endtask

    task automatic t_reset();
        rd(8'h00, rv); chk("R1 ctrl", rv, 0);
        rd(8'h44, rv); chk("R1 raw status", rv, 0);
        rd(8'h40, rv); chk("R1 masked status", rv, 0);
        rd(8'h2C, rv); chk("R1 count", rv, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_preset();
        preset(32'h0000_1234, 32'h89AB_CDEF);
        rd(8'h28, rv); chk("R4 load hi", rv, 32'h1234);
        rd(8'h2C, rv); chk("R4 load lo", rv, 32'h89AB_CDEF);
        rd(8'h30, rv); chk("R4 preset word readback", rv, 32'h1234);
        preset(32'h4000_5555, 32'hFFFF_FFFF);
        rd(8'h28, rv); chk("R4 zero hi", rv, 0);
        rd(8'h2C, rv); chk("R4 zero lo", rv, 0);
    endtask

    task automatic t_run_hold();
        preset(0, 0);
        wr(8'h00, 1); idle(9); wr(8'h00, 0);
        rd(8'h2C, rv); chk("R9 ten steps", rv, 10);
        idle(5);
        rd(8'h2C, rv); chk("R3 hold while stopped", rv, 10);
        rd(8'h00, rv); chk("R3 ctrl readback", rv, 0);
    endtask

    task automatic t_buffered();
        preset(32'h0000_0001, 32'hFFFF_FFFD);
        wr(8'h00, 1);
        rd(8'h20, rv); chk("R2 buffered hi", rv, 32'h1);
        idle(5);
        rd(8'h24, rv); chk("R2 buffered lo from capture", rv, 32'hFFFF_FFFD);
        rd(8'h28, rv); chk("R2 live hi moved on", rv, 32'h2);
        wr(8'h00, 0);
    endtask

    task automatic t_staging();
        wr(8'h10, 32'h0003);
        rd(8'h10, rv); chk("R5 hi not committed yet", rv, 0);
        wr(8'h14, 32'h0000_0010);
        rd(8'h10, rv); chk("R5 hi committed", rv, 32'h3);
        rd(8'h14, rv); chk("R5 lo committed", rv, 32'h10);
    endtask

    task automatic t_match_mask();
        set_cmp(8'h10, 0, 32'h105);
        preset(0, 32'h100);
        wr(8'h00, 1); idle(6); wr(8'h00, 0);
        rd(8'h44, rv); chk("R6 A flag set", rv, 1);
        rd(8'h40, rv); chk("R8 masked while disabled", rv, 0);
        chk("R8 irq while disabled", {31'b0, irq}, 0);
        wr(8'h48, 1);
        rd(8'h40, rv); chk("R8 masked after enable", rv, 1);
        chk("R8 irq after enable", {31'b0, irq}, 1);
        wr(8'h50, 0);
        rd(8'h44, rv); chk("R7 zero write keeps flag", rv, 1);
        wr(8'h4C, 2);
        rd(8'h40, rv); chk("R8 clear of B keeps A enable", rv, 1);
        wr(8'h4C, 1);
        chk("R8 irq after disable", {31'b0, irq}, 0);
        rd(8'h44, rv); chk("R6 flag sticky after disable", rv, 1);
        wr(8'h50, 1);
        rd(8'h44, rv); chk("R7 flag cleared", rv, 0);
    endtask

    task automatic t_cmp_b();
        set_cmp(8'h18, 32'h2, 32'h3);
        preset(32'h2, 0);
        wr(8'h48, 2);
        wr(8'h00, 1); idle(4); wr(8'h00, 0);
        rd(8'h44, rv); chk("R6 B flag set", rv, 2);
        rd(8'h40, rv); chk("R8 B masked", rv, 2);
        chk("R8 irq from B", {31'b0, irq}, 1);
        wr(8'h50, 2);
        rd(8'h44, rv); chk("R7 B cleared", rv, 0);
        chk("R7 irq low after clear", {31'b0, irq}, 0);
        wr(8'h4C, 2);
    endtask

    task automatic t_wrap();
        set_cmp(8'h10, 0, 5);
        set_cmp(8'h18, 0, 7);
        preset(32'h0000_FFFF, 32'hFFFF_FFFE);
        wr(8'h48, 3);
        wr(8'h00, 1); idle(1); wr(8'h00, 0);
        rd(8'h2C, rv); chk("R9 wrapped lo", rv, 0);
        rd(8'h28, rv); chk("R9 wrapped hi", rv, 0);
        rd(8'h44, rv); chk("R9 wrap raises no flag", rv, 0);
        chk("R9 irq low at wrap", {31'b0, irq}, 0);
        wr(8'h4C, 3);
    endtask

    task automatic t_collide();
        set_cmp(8'h10, 0, 32'd100);
        preset(0, 32'd99);
        wr(8'h48, 1);
        wr(8'h00, 1);
        wr(8'h50, 1);
        wr(8'h00, 0);
        rd(8'h44, rv); chk("R7 match beats same-cycle clear", rv, 1);
        chk("R7 irq kept", {31'b0, irq}, 1);
        wr(8'h50, 1);
        rd(8'h44, rv); chk("R7 later clear works", rv, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_preset();
        t_run_hold();
        t_buffered();
        t_staging();
        t_match_mask();
        t_cmp_b();
        t_wrap();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule